// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transceiver

This block is a full-duplex start/stop serial link. It has one transmitter and one receiver. They share a bit-rate generator and a small mode register. A character is eight data bits, least significant bit first, framed by a low start bit and one or two high stop bits. The line idles high. An optional ninth framing bit sits between the data and the stop bits. It carries either even or odd parity, or a multiprocessor address/data marker driven by the sender. When the marker is enabled, the parity settings have no effect.

The mode register loads from the `cfg_*` inputs on a one-cycle `cfg_wr` strobe. It selects:
- the stop count;
- marker framing;
- parity enable and sense;
- one of four prescaler taps: the clock divided by 1, 4, 16 or 64;
- an 8-bit reload value for the bit-rate divider.

The divider produces a tick at sixteen times the bit rate. The receiver counts these ticks to find the middle of each bit.

The receiver samples only the first stop bit. When it has sampled that bit, it returns to idle at once. In two-stop-bit mode, a low level in the second stop position is therefore taken as the start of the next character.

Top module: `sci_async_xcvr`

## Requirements
- R1: After reset, `txd` is 1, `tx_ready` is 1 and `rx_valid` is 0. The mode register reads as all zero: one stop bit, marker off, parity off, tap 00, reload 0. With this mode a character occupies 10 bits of 16 clock cycles each.
- R2: One bit lasts 16·(reload+1)·P clock cycles. P is 1, 4, 16 or 64 for clock select 00, 01, 10 or 11.
- R3: An accepted character is sent in this order: a 0 start bit, then data bits 0 to 7, then the stop bit(s) at 1. `tx_ready` falls after acceptance and rises exactly at the end of the last stop bit. While `tx_ready` is 1, `txd` is 1.
- R4: The transmitter sends one stop bit when the stop control is 0 and two stop bits when it is 1.
- R5: With parity enabled and the marker off, a parity bit follows bit 7. For even sense (parity-odd control 0) it is the XOR of the data. For odd sense it is the inverse.
- R6: The receiver raises `rx_par_err` with the byte when the received parity bit does not match the configured sense.
- R7: With the marker enabled, the ninth bit is `tx_mp_bit` whatever the parity controls say. The receiver reports this bit on `rx_mp_bit` and keeps `rx_par_err` at 0.
- R8: The receiver shifts in eight bits, LSB first, sampled at mid-bit. It pulses `rx_valid` for one cycle, at the middle of the first stop bit, with the byte on `rx_data`.
- R9: A 0 sampled in the first stop bit sets `rx_frame_err` together with the byte.
- R10: In two-stop mode the receiver checks only the first stop bit. A character whose start bit falls in the second stop position is received, and neither character is flagged.
- R11: A low pulse that has ended by mid-bit is rejected as a false start and produces no `rx_valid`.
- R12: The mode fields change only on `cfg_wr`. Changing the `cfg_*` inputs without the strobe leaves the framing unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Load strobe for the mode register |
| cfg_two_stop | input | 1 | 0: one stop bit, 1: two stop bits |
| cfg_mp_en | input | 1 | Enable the multiprocessor marker bit |
| cfg_par_en | input | 1 | Enable parity (ignored when the marker is on) |
| cfg_par_odd | input | 1 | 0: even parity, 1: odd parity |
| cfg_clk_sel | input | 2 | Prescaler tap: 00 ÷1, 01 ÷4, 10 ÷16, 11 ÷64 |
| cfg_div | input | 8 | Bit-rate divider reload value |
| tx_data | input | 8 | Byte to send |
| tx_valid | input | 1 | Byte offered |
| tx_mp_bit | input | 1 | Marker value for the offered byte |
| tx_ready | output | 1 | Transmitter idle, byte accepted when valid |
| txd | output | 1 | Serial transmit line |
| rxd | input | 1 | Serial receive line |
| rx_data | output | 8 | Last received byte |
| rx_valid | output | 1 | One-cycle strobe for a received byte |
| rx_frame_err | output | 1 | First stop bit read as 0 |
| rx_par_err | output | 1 | Parity mismatch |
| rx_mp_bit | output | 1 | Received marker bit |

## Verification
The bench builds the block with its default parameters: 8-bit reload, 16 ticks per bit and 8 data bits. At run time it programs all four prescaler taps and reload values from 0 to 3. This covers bit periods from 16 to 1024 clock cycles, so every framing variant can be checked for exact bit timing within a short run. Loopback from `txd` to `rxd` covers the random mode and data mixes. Frames driven directly by the bench cover bad parity, a low first stop bit, a start bit in the second stop position, and a short false-start pulse.

// File: rtl/sci_pkg.sv
// Shared types for the asynchronous serial transceiver.
// Assumes: the prescaler tap encoding is fixed by the mode field layout.
package sci_pkg;

    typedef enum logic [1:0] {
        PRE_DIV1  = 2'b00,
        PRE_DIV4  = 2'b01,
        PRE_DIV16 = 2'b10,
        PRE_DIV64 = 2'b11
    } presc_e;

    typedef struct packed {
        logic   two_stop;
        logic   mp_en;
        logic   par_en;
        logic   par_odd;
        presc_e presc;
    } mode_t;

endpackage

// File: rtl/sci_baud_gen.sv
// Bit-rate generator: a free-running prescaler offers four taps, and a
// reloadable divider counts the chosen tap's enables to emit tick16,
// one cycle wide, at 16x the bit rate.
// Assumes: the reload value may change at any time; the count is clipped.
module sci_baud_gen
    import sci_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  presc_e           presc,
    input  logic [DIV_W-1:0] reload,
    output logic             tick16
);
    localparam int PRE_W = 6;

    logic [PRE_W-1:0] pre_cnt;
    logic             pre_en;
    logic [DIV_W-1:0] div_cnt;

    // free-running prescaler counter
    always_ff @(posedge clk) begin
        if (!rst_n) pre_cnt <= '0;
        else        pre_cnt <= pre_cnt + 1'b1;
    end

    // tap selection: enable once per 1, 4, 16 or 64 cycles
    always_comb begin
        unique case (presc)
            PRE_DIV1:  pre_en = 1'b1;
            PRE_DIV4:  pre_en = &pre_cnt[1:0];
            PRE_DIV16: pre_en = &pre_cnt[3:0];
            PRE_DIV64: pre_en = &pre_cnt[5:0];
            default:   pre_en = 1'b0;
        endcase
    end

    // reloadable divider producing the oversampling tick
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_cnt <= '0;
            tick16  <= 1'b0;
        end else begin
            tick16 <= 1'b0;
            if (pre_en) begin
                if (div_cnt >= reload) begin
                    div_cnt <= '0;
                    tick16  <= 1'b1;
                end else begin
                    div_cnt <= div_cnt + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/sci_tx.sv
// Transmitter: on acceptance, assembles the whole character (start, data,
// optional parity/marker bit, stop bits) in one shift register. It waits
// for a tick boundary, then shifts one bit every OVS ticks.
// Assumes: mode inputs are stable while a character is in flight.
module sci_tx #(
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick16,
    input  logic              two_stop,
    input  logic              mp_en,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_valid,
    input  logic              tx_mp_bit,
    output logic              tx_ready,
    output logic              txd
);
    localparam int FW   = DATA_W + 4;
    localparam int CW   = $clog2(FW + 1);
    localparam int TC_W = $clog2(OVS);

    typedef enum logic [1:0] {TX_IDLE, TX_ARM, TX_SEND} tx_st_e;

    tx_st_e          st;
    logic [FW-1:0]   shreg;
    logic [FW-1:0]   frame;
    logic [CW-1:0]   nbits;
    logic [CW-1:0]   bitno;
    logic [TC_W-1:0] tcnt;
    logic            extra_en;

    assign extra_en = mp_en | par_en;

    // character assembly from the offered byte and the mode
    always_comb begin
        frame             = '1;
        frame[0]          = 1'b0;
        frame[DATA_W:1]   = tx_data;
        if (mp_en)
            frame[DATA_W+1] = tx_mp_bit;
        else if (par_en)
            frame[DATA_W+1] = par_odd ^ (^tx_data);
    end

    // accept, align to tick, and shift out bit by bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= TX_IDLE;
            shreg <= '1;
            nbits <= '0;
            bitno <= '0;
            tcnt  <= '0;
        end else begin
            unique case (st)
                TX_IDLE: if (tx_valid) begin
                    shreg <= frame;
                    nbits <= CW'(DATA_W + 2) + CW'(extra_en) + CW'(two_stop);
                    bitno <= '0;
                    tcnt  <= '0;
                    st    <= TX_ARM;
                end
                TX_ARM: if (tick16) st <= TX_SEND;
                TX_SEND: if (tick16) begin
                    tcnt <= tcnt + 1'b1;
                    if (tcnt == TC_W'(OVS - 1)) begin
                        shreg <= {1'b1, shreg[FW-1:1]};
                        bitno <= bitno + 1'b1;
                        if (bitno == nbits - 1'b1) st <= TX_IDLE;
                    end
                end
                default: st <= TX_IDLE;
            endcase
        end
    end

    assign tx_ready = (st == TX_IDLE);
    assign txd      = (st == TX_SEND) ? shreg[0] : 1'b1;

endmodule

// File: rtl/sci_rx.sv
// Receiver: synchronises the line, detects a falling edge and confirms the
// start bit at mid-bit. It samples data, then the optional ninth bit, then
// only the first stop bit, and returns to idle at once, so a 0 in a
// second stop position starts the next character.
// Assumes: tick16 runs at OVS times the bit rate of the sender.
module sci_rx #(
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick16,
    input  logic              mp_en,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              rxd,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              rx_frame_err,
    output logic              rx_par_err,
    output logic              rx_mp_bit
);
    localparam int TC_W = $clog2(OVS);
    localparam int BN_W = $clog2(DATA_W + 1);
    localparam int HALF = OVS / 2;

    typedef enum logic [2:0] {RX_IDLE, RX_START, RX_DATA, RX_EXTRA, RX_STOP} rx_st_e;

    rx_st_e            st;
    logic              s1, s2, s3;
    logic [TC_W-1:0]   tcnt;
    logic [BN_W-1:0]   bitno;
    logic [DATA_W-1:0] shreg;
    logic              xbit;
    logic              mid;

    // two-stage synchroniser plus a delayed copy for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) {s1, s2, s3} <= 3'b111;
        else        {s1, s2, s3} <= {rxd, s1, s2};
    end

    assign mid = tick16 && (tcnt == TC_W'(OVS - 1));

    // framing state machine with mid-bit sampling
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st           <= RX_IDLE;
            tcnt         <= '0;
            bitno        <= '0;
            shreg        <= '0;
            xbit         <= 1'b0;
            rx_data      <= '0;
            rx_valid     <= 1'b0;
            rx_frame_err <= 1'b0;
            rx_par_err   <= 1'b0;
            rx_mp_bit    <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            if (tick16 && st != RX_IDLE) tcnt <= tcnt + 1'b1;
            unique case (st)
                RX_IDLE: if (!s2 && s3) begin
                    tcnt <= '0;
                    st   <= RX_START;
                end
                RX_START: if (tick16 && tcnt == TC_W'(HALF - 1)) begin
                    tcnt  <= '0;
                    bitno <= '0;
                    st    <= s2 ? RX_IDLE : RX_DATA;
                end
                RX_DATA: if (mid) begin
                    shreg <= {s2, shreg[DATA_W-1:1]};
                    bitno <= bitno + 1'b1;
                    if (bitno == BN_W'(DATA_W - 1))
                        st <= (mp_en || par_en) ? RX_EXTRA : RX_STOP;
                end
                RX_EXTRA: if (mid) begin
                    xbit <= s2;
                    st   <= RX_STOP;
                end
                RX_STOP: if (mid) begin
                    rx_valid     <= 1'b1;
                    rx_data      <= shreg;
                    rx_frame_err <= !s2;
                    rx_par_err   <= !mp_en && par_en && (xbit ^ (^shreg) ^ par_odd);
                    rx_mp_bit    <= mp_en && xbit;
                    st           <= RX_IDLE;
                end
                default: st <= RX_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/sci_async_xcvr.sv
// Top of the asynchronous serial transceiver: holds the mode register and
// wires the bit-rate generator, transmitter and receiver together.
// Assumes: cfg_wr is not pulsed while a character is in flight.
module sci_async_xcvr
    import sci_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 8,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic              cfg_two_stop,
    input  logic              cfg_mp_en,
    input  logic              cfg_par_en,
    input  logic              cfg_par_odd,
    input  logic [1:0]        cfg_clk_sel,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_valid,
    input  logic              tx_mp_bit,
    output logic              tx_ready,
    output logic              txd,
    input  logic              rxd,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              rx_frame_err,
    output logic              rx_par_err,
    output logic              rx_mp_bit
);
    mode_t            mode_q;
    logic [DIV_W-1:0] div_q;
    logic             tick16;

    // mode register, loaded only on the strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
            div_q  <= '0;
        end else if (cfg_wr) begin
            mode_q <= '{two_stop: cfg_two_stop, mp_en: cfg_mp_en, par_en: cfg_par_en,
                        par_odd: cfg_par_odd, presc: presc_e'(cfg_clk_sel)};
            div_q  <= cfg_div;
        end
    end

    sci_baud_gen #(.DIV_W(DIV_W)) u_baud (
        .clk    (clk),
        .rst_n  (rst_n),
        .presc  (mode_q.presc),
        .reload (div_q),
        .tick16 (tick16)
    );

    sci_tx #(.DATA_W(DATA_W), .OVS(OVS)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick16    (tick16),
        .two_stop  (mode_q.two_stop),
        .mp_en     (mode_q.mp_en),
        .par_en    (mode_q.par_en),
        .par_odd   (mode_q.par_odd),
        .tx_data   (tx_data),
        .tx_valid  (tx_valid),
        .tx_mp_bit (tx_mp_bit),
        .tx_ready  (tx_ready),
        .txd       (txd)
    );

    sci_rx #(.DATA_W(DATA_W), .OVS(OVS)) u_rx (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick16       (tick16),
        .mp_en        (mode_q.mp_en),
        .par_en       (mode_q.par_en),
        .par_odd      (mode_q.par_odd),
        .rxd          (rxd),
        .rx_data      (rx_data),
        .rx_valid     (rx_valid),
        .rx_frame_err (rx_frame_err),
        .rx_par_err   (rx_par_err),
        .rx_mp_bit    (rx_mp_bit)
    );

endmodule

// File: rtl/sci_async_xcvr_chk.sv
// Property checker for the transceiver's port-level handshake and framing
// rules; attached to the top module by the bind below.
module sci_async_xcvr_chk (
    input logic clk,
    input logic rst_n,
    input logic tx_valid,
    input logic tx_ready,
    input logic txd,
    input logic rx_valid,
    input logic rx_par_err,
    input logic mp_en
);
    // R3
    txd_idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |-> txd);

    // R3
    tx_accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && tx_ready |=> !tx_ready);

    // R8
    rx_valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R7
    mp_no_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid && $past(mp_en) |-> !rx_par_err);

endmodule

bind sci_async_xcvr sci_async_xcvr_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_valid   (tx_valid),
    .tx_ready   (tx_ready),
    .txd        (txd),
    .rx_valid   (rx_valid),
    .rx_par_err (rx_par_err),
    .mp_en      (mode_q.mp_en)
);

// File: tb/sci_async_xcvr_bench.sv
module sci_async_xcvr_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr = 1'b0, cfg_two_stop = 1'b0, cfg_mp_en = 1'b0;
    logic       cfg_par_en = 1'b0, cfg_par_odd = 1'b0;
    logic [1:0] cfg_clk_sel = 2'b00;
    logic [7:0] cfg_div = 8'd0;
    logic [7:0] tx_data = 8'd0;
    logic       tx_valid = 1'b0, tx_mp_bit = 1'b0;
    logic       tx_ready, txd, rxd;
    logic [7:0] rx_data;
    logic       rx_valid, rx_frame_err, rx_par_err, rx_mp_bit;
    logic       loop_en = 1'b1, drv_rxd = 1'b1;

    int checks = 0, errors = 0, cyc = 0, rx_cnt = 0;
    logic [7:0] log_d  [64];
    logic       log_fe [64];
    logic       log_pe [64];
    logic       log_mp [64];

    // shadow of the programmed mode
    bit m_two = 0, m_mp = 0, m_pe = 0, m_po = 0;
    int m_sel = 0, m_div = 0;

    assign rxd = loop_en ? txd : drv_rxd;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    sci_async_xcvr u_sci_async_xcvr (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_two_stop(cfg_two_stop),
        .cfg_mp_en(cfg_mp_en), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .cfg_clk_sel(cfg_clk_sel), .cfg_div(cfg_div), .tx_data(tx_data),
        .tx_valid(tx_valid), .tx_mp_bit(tx_mp_bit), .tx_ready(tx_ready), .txd(txd),
        .rxd(rxd), .rx_data(rx_data), .rx_valid(rx_valid), .rx_frame_err(rx_frame_err),
        .rx_par_err(rx_par_err), .rx_mp_bit(rx_mp_bit)
    );

    // receive log
    always @(negedge clk) begin
        if (rst_n && rx_valid) begin
            log_d[rx_cnt % 64]  = rx_data;
            log_fe[rx_cnt % 64] = rx_frame_err;
            log_pe[rx_cnt % 64] = rx_par_err;
            log_mp[rx_cnt % 64] = rx_mp_bit;
            rx_cnt = rx_cnt + 1;
        end
    end

    function automatic int bit_cyc(int sel, int dv);
        return 16 * (dv + 1) * (1 << (2 * sel));
    endfunction

    function automatic logic [11:0] exp_frame(logic [7:0] d, bit mp, bit pe, bit po, logic mpb);
        logic [11:0] f;
        f = '1;
        f[0] = 1'b0;
        f[8:1] = d;
        if (mp)      f[9] = mpb;
        else if (pe) f[9] = po ^ (^d);
        return f;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int target);
        while (cyc < target) @(negedge clk);
    endtask

    task automatic set_mode(input bit two, input bit mp, input bit pe, input bit po,
                            input int sel, input int dv);
        @(negedge clk);
        cfg_two_stop = two; cfg_mp_en = mp; cfg_par_en = pe; cfg_par_odd = po;
        cfg_clk_sel = 2'(sel); cfg_div = 8'(dv); cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
        m_two = two; m_mp = mp; m_pe = pe; m_po = po; m_sel = sel; m_div = dv;
    endtask

    // send one byte, decode txd at mid-bit, check length and loopback result
    task automatic tx_frame(input logic [7:0] d, input logic mpb, input string req);
        int nb, bc, t0, c0;
        logic [11:0] got, exp;
        nb  = 10 + ((m_mp || m_pe) ? 1 : 0) + (m_two ? 1 : 0);
        bc  = bit_cyc(m_sel, m_div);
        exp = exp_frame(d, m_mp, m_pe, m_po, mpb);
        got = '1;
        c0  = rx_cnt;
        while (tx_ready !== 1'b1) @(negedge clk);
        tx_data = d; tx_mp_bit = mpb; tx_valid = 1'b1;
        @(negedge clk);
        tx_valid = 1'b0;
        while (txd !== 1'b0) @(negedge clk);
        t0 = cyc;
        for (int i = 0; i < nb; i++) begin
            wait_cyc(t0 + i * bc + bc / 2);
            got[i] = txd;
        end
        while (tx_ready !== 1'b1) @(negedge clk);
        chk({req, " frame bits"}, 32'(got), 32'(exp));
        chk({req, " frame length"}, cyc - t0, nb * bc);
        if (loop_en) begin
            repeat (4) @(negedge clk);
            chk({req, " R8 rx count"}, rx_cnt, c0 + 1);
            chk({req, " R8 rx data"}, 32'(log_d[c0 % 64]), 32'(d));
            chk({req, " R9 no frame err"}, 32'(log_fe[c0 % 64]), 0);
            chk({req, " R6 no parity err"}, 32'(log_pe[c0 % 64]), 0);
            chk({req, " R7 rx marker"}, 32'(log_mp[c0 % 64]), 32'(m_mp && mpb));
        end
    endtask

    // drive n raw bits on the receive line, LSB first, bc cycles each
    task automatic drive_bits(input logic [31:0] v, input int n, input int bc);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            drv_rxd = v[i];
            repeat (bc - 1) @(negedge clk);
        end
        @(negedge clk);
        drv_rxd = 1'b1;
        repeat (3 * bc) @(negedge clk);
    endtask

    // watchdog
    initial begin
        wait (cyc > 190000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected<190000", cyc);
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int c0;
        logic [7:0] d1, d2;
        void'($urandom(32'h5EED));
        repeat (4) @(negedge clk);
        // R1 reset state
        chk("R1 txd idle", 32'(txd), 1);
        chk("R1 tx_ready", 32'(tx_ready), 1);
        chk("R1 rx_valid", 32'(rx_valid), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 txd after reset", 32'(txd), 1);

        // R1 reset mode: 10 bits of 16 cycles, no write made
        tx_frame(8'hA5, 1'b0, "R1 R3 default mode");
        tx_frame(8'h01, 1'b0, "R3 lsb first");

        // R2 prescaler taps and reload values
        set_mode(0, 0, 0, 0, 0, 3); tx_frame(8'h5A, 1'b0, "R2 sel00 div3");
        set_mode(0, 0, 0, 0, 1, 1); tx_frame(8'hC3, 1'b0, "R2 sel01 div1");
        set_mode(0, 0, 0, 0, 2, 0); tx_frame(8'h3C, 1'b0, "R2 sel10 div0");
        set_mode(0, 0, 0, 0, 3, 0); tx_frame(8'h96, 1'b0, "R2 sel11 div0");

        // R4 two stop bits
        set_mode(1, 0, 0, 0, 0, 0); tx_frame(8'hF0, 1'b0, "R4 two stop");

        // R5 parity even and odd
        set_mode(0, 0, 1, 0, 0, 0); tx_frame(8'h07, 1'b0, "R5 even parity");
        set_mode(1, 0, 1, 1, 0, 1); tx_frame(8'h07, 1'b0, "R5 odd parity");

        // R7 marker overrides parity
        set_mode(0, 1, 1, 1, 0, 0); tx_frame(8'h81, 1'b1, "R7 marker one");
        tx_frame(8'h81, 1'b0, "R7 marker zero");

        // R12 inputs change without strobe: framing unchanged
        set_mode(0, 0, 0, 0, 0, 0);
        @(negedge clk);
        cfg_two_stop = 1'b1; cfg_par_en = 1'b1; cfg_div = 8'd5;
        tx_frame(8'h44, 1'b0, "R12 no strobe");

        // R6 bad parity driven on the line (even sense, 0x3C needs 0)
        loop_en = 1'b0;
        set_mode(0, 0, 1, 0, 0, 0);
        c0 = rx_cnt;
        drive_bits({21'h0, 1'b1, 1'b1, 8'h3C, 1'b0}, 11, 16);
        chk("R6 rx count", rx_cnt, c0 + 1);
        chk("R6 parity err", 32'(log_pe[c0 % 64]), 1);
        chk("R6 data", 32'(log_d[c0 % 64]), 32'h3C);

        // R9 framing error: first stop bit low
        set_mode(0, 0, 0, 0, 0, 0);
        c0 = rx_cnt;
        drive_bits({22'h0, 1'b0, 8'h6B, 1'b0}, 10, 16);
        chk("R9 rx count", rx_cnt, c0 + 1);
        chk("R9 frame err", 32'(log_fe[c0 % 64]), 1);
        chk("R9 data", 32'(log_d[c0 % 64]), 32'h6B);

        // R10 start bit in second stop position, two-stop mode
        set_mode(1, 0, 0, 0, 0, 0);
        d1 = 8'hD2; d2 = 8'h2D;
        c0 = rx_cnt;
        drive_bits({11'h0, 2'b11, d2, 1'b0, 1'b1, d1, 1'b0}, 21, 16);
        chk("R10 rx count", rx_cnt, c0 + 2);
        chk("R10 first data", 32'(log_d[c0 % 64]), 32'(d1));
        chk("R10 second data", 32'(log_d[(c0 + 1) % 64]), 32'(d2));
        chk("R10 first no frame err", 32'(log_fe[c0 % 64]), 0);
        chk("R10 second no frame err", 32'(log_fe[(c0 + 1) % 64]), 0);

        // R11 false start: low for a quarter bit
        set_mode(0, 0, 0, 0, 0, 3);
        c0 = rx_cnt;
        @(negedge clk); drv_rxd = 1'b0;
        repeat (16) @(negedge clk);
        drv_rxd = 1'b1;
        repeat (64 * 12) @(negedge clk);
        chk("R11 no rx_valid", rx_cnt, c0);
        drive_bits({22'h0, 1'b1, 8'hE7, 1'b0}, 10, 64);
        chk("R11 later frame received", 32'(log_d[c0 % 64]), 32'hE7);

        // random modes and data through loopback
        loop_en = 1'b1;
        for (int k = 0; k < 24; k++) begin
            set_mode(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                     0, int'($urandom % 4));
            tx_frame(8'($urandom), 1'($urandom), "R8 random");
        end

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule